// File: doc/BRIEF.md
# Interrupt Event Assignment Lookup Stage

This block is the front stage of an interrupt routing engine. It takes in one event notification at a time. Each notification carries a 32-bit logical source number. The block splits the number into a table block and an index within that block. It then fetches the 64-bit assignment entry for that source through a read port that uses a request/response handshake.

When the entry comes back, the block gives the event exactly one of four outcomes:

- **Unknown source:** the read failed.
- **Invalid source:** the entry is not valid.
- **Masked:** the entry is masked. The event counts as complete, and nothing is sent downstream.
- **Forwarded:** the event goes to the next stage with the destination descriptor block, the descriptor index, the data value and the original source number.

The entry uses big-endian bit numbering, so entry bit 0 is the most significant bit of the word.

Each outcome is a registered pulse that lasts one cycle. A new notification is taken only while the block is idle. This keeps a single lookup in flight at a time.

Top module: `evt_assign_lookup`

## Requirements
- R1: The read request carries block = source bits [31:28] and index = source bits [27:0] of the accepted notification.
- R2: `ntf_ready` is high only when the block is idle. From the cycle after acceptance until the outcome pulse, `ntf_ready` is low, and notifications presented during that time have no effect on the outcome or its source number.
- R3: `rd_req_valid` stays high with stable block and index until `rd_req_ready` is seen. Exactly one request is issued per accepted notification.
- R4: A response with `rd_rsp_err` high gives an `err_unknown` pulse, with `err_src` equal to the source number. No other outcome is raised, whatever the entry holds.
- R5: A response with no error and entry word bit 63 (big-endian bit 0, the valid flag) clear gives an `err_invalid` pulse, with `err_src` equal to the source number. This holds even when the mask flag is set, because the valid check comes first.
- R6: A valid entry with word bit 31 (big-endian bit 32, the mask flag) set gives a `done_masked` pulse. It raises no error and forwards nothing.
- R7: A valid, unmasked entry gives a `fwd_valid` pulse with the following fields:
  - `fwd_dblk` = word bits [59:56] (big-endian 4..7)
  - `fwd_didx` = word bits [55:32] (big-endian 8..31)
  - `fwd_data` = word bits [30:0] (big-endian 33..63)
  - `fwd_src` = the source number
- R8: Each accepted notification produces exactly one outcome pulse, one cycle long, in the cycle after the response handshake. At most one outcome output is high in any cycle.
- R9: After reset, `ntf_ready` is high and `rd_req_valid` and all outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notification present |
| ntf_src | input | 32 | Logical source number |
| ntf_ready | output | 1 | Block idle, notification accepted |
| rd_req_valid | output | 1 | Table read request valid |
| rd_req_ready | input | 1 | Table read request taken |
| rd_req_blk | output | 4 | Table block number |
| rd_req_idx | output | 28 | Index within the block |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_entry | input | 64 | Assignment entry word |
| rd_rsp_err | input | 1 | Read failed |
| fwd_valid | output | 1 | Forward pulse |
| fwd_dblk | output | 4 | Destination descriptor block |
| fwd_didx | output | 24 | Destination descriptor index |
| fwd_data | output | 31 | Event data |
| fwd_src | output | 32 | Source number of the forwarded event |
| err_unknown | output | 1 | Failed-read pulse |
| err_invalid | output | 1 | Invalid-entry pulse |
| err_src | output | 32 | Source number of the errored event |
| done_masked | output | 1 | Masked-completion pulse |

## Verification
The assertions assume the table side plays by the rules:
- a response arrives only while a lookup is waiting for one;
- the response lasts exactly one cycle;
- `rd_req_ready` is only of interest while a request is pending.

The bench drives the memory side from a single task per lookup. That task raises the response only after the request handshake and drops it on the next cycle. It also delays both the request grant and the response by 0 to 2 cycles.

The bench sweeps every combination of read error, valid flag and mask flag over sixteen sources, one for each block number. On half of the lookups it presents a stray notification while the block is busy.

// File: rtl/eal_pkg.sv
package eal_pkg;
  typedef enum logic [1:0] {
    OC_UNKNOWN = 2'd0,
    OC_INVALID = 2'd1,
    OC_MASKED  = 2'd2,
    OC_FWD     = 2'd3
  } outcome_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lk_state_t;
endpackage

// File: rtl/eal_entry_decode.sv
module eal_entry_decode
  import eal_pkg::*;
#(
  parameter int ENT_W  = 64,
  parameter int DBLK_W = 4,
  parameter int DIDX_W = 24
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic              rd_err,
  output outcome_t          outcome,
  output logic [DBLK_W-1:0] dblk,
  output logic [DIDX_W-1:0] didx,
  output logic [ENT_W/2-2:0] data
);
  // big-endian bit b sits at little-endian position ENT_W-1-b
  localparam int VLD_POS  = ENT_W - 1;          // BE 0
  localparam int DBLK_HI  = ENT_W - 1 - 4;      // BE 4
  localparam int DIDX_HI  = DBLK_HI - DBLK_W;   // BE 8
  localparam int MSK_POS  = ENT_W - 1 - 32;     // BE 32
  localparam int DATA_W   = ENT_W / 2 - 1;      // BE 33..63

  logic vld, msk;

  always_comb begin
    vld  = entry[VLD_POS];
    msk  = entry[MSK_POS];
    dblk = entry[DBLK_HI -: DBLK_W];
    didx = entry[DIDX_HI -: DIDX_W];
    data = entry[DATA_W-1:0];
    if (rd_err)      outcome = OC_UNKNOWN;
    else if (!vld)   outcome = OC_INVALID;
    else if (msk)    outcome = OC_MASKED;
    else             outcome = OC_FWD;
  end
endmodule

// File: rtl/eal_ctrl.sv
module eal_ctrl
  import eal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ntf_valid,
  input  logic rd_req_ready,
  input  logic rd_rsp_valid,
  output logic accept,
  output logic issue,
  output logic capture
);
  lk_state_t st, st_nxt;

  assign accept  = (st == ST_IDLE) && ntf_valid;
  assign issue   = (st == ST_REQ);
  assign capture = (st == ST_WAIT) && rd_rsp_valid;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (ntf_valid)    st_nxt = ST_REQ;
      ST_REQ:  if (rd_req_ready) st_nxt = ST_WAIT;
      ST_WAIT: if (rd_rsp_valid) st_nxt = ST_IDLE;
      default:                   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/evt_assign_lookup.sv
module evt_assign_lookup
  import eal_pkg::*;
#(
  parameter int SRC_W  = 32,
  parameter int BLK_W  = 4,
  parameter int ENT_W  = 64,
  parameter int DBLK_W = 4,
  parameter int DIDX_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ntf_valid,
  input  logic [SRC_W-1:0]       ntf_src,
  output logic                   ntf_ready,
  output logic                   rd_req_valid,
  input  logic                   rd_req_ready,
  output logic [BLK_W-1:0]       rd_req_blk,
  output logic [SRC_W-BLK_W-1:0] rd_req_idx,
  input  logic                   rd_rsp_valid,
  input  logic [ENT_W-1:0]       rd_rsp_entry,
  input  logic                   rd_rsp_err,
  output logic                   fwd_valid,
  output logic [DBLK_W-1:0]      fwd_dblk,
  output logic [DIDX_W-1:0]      fwd_didx,
  output logic [ENT_W/2-2:0]     fwd_data,
  output logic [SRC_W-1:0]       fwd_src,
  output logic                   err_unknown,
  output logic                   err_invalid,
  output logic [SRC_W-1:0]       err_src,
  output logic                   done_masked
);
  localparam int IDX_W  = SRC_W - BLK_W;
  localparam int DATA_W = ENT_W / 2 - 1;

  logic             accept, issue, capture;
  logic [SRC_W-1:0] src_q;
  outcome_t         oc;
  logic [DBLK_W-1:0] d_dblk;
  logic [DIDX_W-1:0] d_didx;
  logic [DATA_W-1:0] d_data;

  eal_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ntf_valid(ntf_valid),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
    .accept(accept), .issue(issue), .capture(capture)
  );

  eal_entry_decode #(.ENT_W(ENT_W), .DBLK_W(DBLK_W), .DIDX_W(DIDX_W)) u_dec (
    .entry(rd_rsp_entry), .rd_err(rd_rsp_err), .outcome(oc),
    .dblk(d_dblk), .didx(d_didx), .data(d_data)
  );

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else if (accept) src_q <= ntf_src;
  end

  // idle is exactly the state in which no request is issued and none waits
  assign ntf_ready    = ~issue & ~u_ctrl.st[1];
  assign rd_req_valid = issue;
  assign rd_req_blk   = src_q[SRC_W-1 -: BLK_W];
  assign rd_req_idx   = src_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid   <= 1'b0;
      err_unknown <= 1'b0;
      err_invalid <= 1'b0;
      done_masked <= 1'b0;
      fwd_dblk    <= '0;
      fwd_didx    <= '0;
      fwd_data    <= '0;
      fwd_src     <= '0;
      err_src     <= '0;
    end else begin
      fwd_valid   <= capture && (oc == OC_FWD);
      err_unknown <= capture && (oc == OC_UNKNOWN);
      err_invalid <= capture && (oc == OC_INVALID);
      done_masked <= capture && (oc == OC_MASKED);
      if (capture && oc == OC_FWD) begin
        fwd_dblk <= d_dblk;
        fwd_didx <= d_didx;
        fwd_data <= d_data;
        fwd_src  <= src_q;
      end
      if (capture && (oc == OC_UNKNOWN || oc == OC_INVALID))
        err_src <= src_q;
    end
  end
endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
  parameter int SRC_W = 32,
  parameter int BLK_W = 4,
  parameter int ENT_W = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ntf_valid,
  input logic [SRC_W-1:0]       ntf_src,
  input logic                   ntf_ready,
  input logic                   rd_req_valid,
  input logic                   rd_req_ready,
  input logic [BLK_W-1:0]       rd_req_blk,
  input logic [SRC_W-BLK_W-1:0] rd_req_idx,
  input logic                   rd_rsp_valid,
  input logic [ENT_W-1:0]       rd_rsp_entry,
  input logic                   rd_rsp_err,
  input logic                   fwd_valid,
  input logic [SRC_W-1:0]       fwd_src,
  input logic                   err_unknown,
  input logic                   err_invalid,
  input logic [SRC_W-1:0]       err_src,
  input logic                   done_masked
);
  logic [SRC_W-1:0] trk_src;
  always_ff @(posedge clk) begin
    if (rst) trk_src <= '0;
    else if (ntf_valid && ntf_ready) trk_src <= ntf_src;
  end

  AST_REQ_SPLIT: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> {rd_req_blk, rd_req_idx} == trk_src);  // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> !ntf_ready);  // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_blk) && $stable(rd_req_idx));  // R3
  AST_UNKNOWN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_unknown |-> $past(rd_rsp_valid && rd_rsp_err) && err_src == trk_src);  // R4
  AST_INVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_invalid |-> $past(rd_rsp_valid && !rd_rsp_err && !rd_rsp_entry[ENT_W-1]));  // R5
  AST_MASKED_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done_masked |-> $past(rd_rsp_valid && !rd_rsp_err && rd_rsp_entry[ENT_W-1] && rd_rsp_entry[ENT_W-33]));  // R6
  AST_FWD_SRC: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> fwd_src == trk_src);  // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_valid, err_unknown, err_invalid, done_masked}));  // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid || err_unknown || err_invalid || done_masked)
      |=> !(fwd_valid || err_unknown || err_invalid || done_masked));  // R8
endmodule

bind evt_assign_lookup eal_checker #(.SRC_W(SRC_W), .BLK_W(BLK_W), .ENT_W(ENT_W)) u_chk (.*);

// File: tb/evt_assign_lookup_tb.sv
module evt_assign_lookup_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ntf_valid = 1'b0;
  logic [31:0] ntf_src = '0;
  logic        ntf_ready;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [3:0]  rd_req_blk;
  logic [27:0] rd_req_idx;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_entry = '0;
  logic        rd_rsp_err = 1'b0;
  logic        fwd_valid;
  logic [3:0]  fwd_dblk;
  logic [23:0] fwd_didx;
  logic [30:0] fwd_data;
  logic [31:0] fwd_src;
  logic        err_unknown, err_invalid, done_masked;
  logic [31:0] err_src;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  evt_assign_lookup u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] src, input bit err, input bit v, input bit m,
                        input logic [3:0] dblk, input logic [23:0] didx, input logic [30:0] data,
                        input int dly_req, input int dly_rsp, input bit stray);
    logic [63:0] ent;
    ent = ({63'd0, v} << 63) | (64'h5 << 60) | ({60'd0, dblk} << 56) | ({40'd0, didx} << 32)
        | ({63'd0, m} << 31) | {33'd0, data};
    @(negedge clk);
    chk(ntf_ready == 1'b1, "R2 idle ready", {63'd0, ntf_ready}, 64'd1);
    ntf_valid = 1'b1; ntf_src = src;
    @(negedge clk);
    ntf_valid = 1'b0;
    chk(ntf_ready == 1'b0, "R2 busy not ready", {63'd0, ntf_ready}, 64'd0);
    chk(rd_req_valid && {rd_req_blk, rd_req_idx} == src, "R1 split",
        {32'd0, rd_req_blk, rd_req_idx}, {32'd0, src});
    for (int k = 0; k < dly_req; k++) begin
      if (stray) begin ntf_valid = 1'b1; ntf_src = ~src; end
      @(negedge clk);
      ntf_valid = 1'b0;
      chk(rd_req_valid && {rd_req_blk, rd_req_idx} == src, "R3 hold",
          {32'd0, rd_req_blk, rd_req_idx}, {32'd0, src});
    end
    rd_req_ready = 1'b1;
    if (stray) begin ntf_valid = 1'b1; ntf_src = ~src; end
    @(negedge clk);
    rd_req_ready = 1'b0; ntf_valid = 1'b0;
    chk(!rd_req_valid, "R3 single request", {63'd0, rd_req_valid}, 64'd0);
    for (int k = 0; k < dly_rsp; k++) @(negedge clk);
    rd_rsp_valid = 1'b1; rd_rsp_entry = ent; rd_rsp_err = err;
    @(negedge clk);
    rd_rsp_valid = 1'b0; rd_rsp_entry = '0; rd_rsp_err = 1'b0;
    if (err) begin
      chk(err_unknown && !err_invalid && !done_masked && !fwd_valid, "R4 unknown",
          {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'h8);
      chk(err_src == src, "R4 err_src", {32'd0, err_src}, {32'd0, src});
    end else if (!v) begin
      chk(err_invalid && !err_unknown && !done_masked && !fwd_valid, "R5 invalid",
          {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'h4);
      chk(err_src == src, "R5 err_src", {32'd0, err_src}, {32'd0, src});
    end else if (m) begin
      chk(done_masked && !err_invalid && !err_unknown && !fwd_valid, "R6 masked",
          {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'h2);
    end else begin
      chk(fwd_valid && !err_invalid && !err_unknown && !done_masked, "R7 forward",
          {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'h1);
      chk(fwd_dblk == dblk, "R7 dblk", {60'd0, fwd_dblk}, {60'd0, dblk});
      chk(fwd_didx == didx, "R7 didx", {40'd0, fwd_didx}, {40'd0, didx});
      chk(fwd_data == data, "R7 data", {33'd0, fwd_data}, {33'd0, data});
      chk(fwd_src == src, "R2 R7 src", {32'd0, fwd_src}, {32'd0, src});
    end
    @(negedge clk);
    chk(!(fwd_valid || err_unknown || err_invalid || done_masked), "R8 one cycle",
        {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(ntf_ready && !rd_req_valid, "R9 reset ready", {62'd0, ntf_ready, rd_req_valid}, 64'h2);
    chk(!(fwd_valid || err_unknown || err_invalid || done_masked), "R9 reset pulses",
        {60'd0, err_unknown, err_invalid, done_masked, fwd_valid}, 64'd0);
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] s;
        s = {i[3:0], 28'(i * 32'h0123457 + 5 + c)};
        lookup(s, c[2], c[1], c[0], 4'(i + c), 24'(i * 32'h13579 ^ c),
               31'(i * 32'h2468ACE + c * 77), (i + c) % 3, (i + 2 * c) % 3, i[0]);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule